// File: doc/BRIEF.md
# Bridge Error Interrupt Status Register

This block holds the interrupt status word for the primary side of a bus bridge. Single-cycle event strobes report error and power-management conditions that have already been qualified elsewhere. The events covered are parity errors, aborts, system-error assertion and power-state transitions. Each condition is latched into its own sticky status bit. Any set bit drives one level interrupt toward the local processor.

Software on the local bus reads the word and clears bits by writing ones. The configuration side sees the same word through a read-only port. A per-bit mask can stop a condition from being latched here. A parallel copy of six of these bits stands for the main status register. That copy is set by the same strobes on the same cycle, ignores the mask, and has its own write-one-to-clear path.

The mask input has one bit per status bit, index b for status bit b. The surrounding control register supplies it from its bits 10, 9, 8, 7, 6, 4 and 1, which feed mask bits 6 down to 0 in that order.

Top module: `brg_err_irq_stat`

## Requirements
- R1: After reset every status bit, every main-copy bit and `irq_o` are 0.
- R2: Bits 31:7 of both read ports are always 0, and `cfg_rd_data_o` always equals `lb_rd_data_o`.
- R3: A local-bus write with `lb_wr_en_i` high clears each status bit b whose `lb_clr_i[b]` is 1 on the next cycle and leaves bits with a 0 unchanged.
- R4: An unmasked event sets its status bit on the cycle after the strobe. When a set and a clear hit the same bit in one cycle, the bit ends up set.
- R5: Main-copy bits 15, 14, 13, 12, 11 and 8 of `main_stat_o` are set by the same events as status bits 5, 4, 3, 2, 1 and 0, on the same cycle. Main-copy bits are cleared only by `main_clr_en_i`, with `main_clr_i[k]` mapping to status-bit order k = 0..5. All other main-copy bits read 0.
- R6: When `evt_mask_i[b]` is 1, an event for bit b leaves status bit b unchanged, but still sets the matching main-copy bit.
- R7: Bit 6 sets only on `pwr_wr_i` with a transition from D3 (2'b11) to D0 (2'b00) or from D0 to D3. All other old/new pairs do not set it.
- R8: Bit 5 sets on a write-data parity error as target, a read-data parity error as master, or any address parity error. It does not depend on `par_chk_en_i`.
- R9: Bit 4 sets on `serr_i`, bit 3 on `mabt_mst_i`, bit 2 on `tabt_mst_i`, and bit 1 on `tabt_tgt_i`.
- R10: Bit 0 sets only when `perr_i`, `perr_mst_i` and `par_chk_en_i` are all 1 in the same cycle.
- R11: `irq_o` is 1 exactly when any of status bits 6:0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pwr_wr_i | input | 1 | Power-state field write strobe |
| pwr_old_i | input | 2 | Power state before the write |
| pwr_new_i | input | 2 | Power state being written |
| wdpe_tgt_i | input | 1 | Write-data parity error, bridge as target |
| rdpe_mst_i | input | 1 | Read-data parity error, bridge as master |
| adpe_i | input | 1 | Address parity error seen on the bus |
| serr_i | input | 1 | System-error line seen asserted |
| mabt_mst_i | input | 1 | Mastered transaction ended in master-abort |
| tabt_mst_i | input | 1 | Mastered transaction ended in target-abort |
| tabt_tgt_i | input | 1 | Bridge as target signalled target-abort |
| perr_i | input | 1 | Parity-error line driven or seen |
| perr_mst_i | input | 1 | Bridge mastered the transaction with the parity error |
| par_chk_en_i | input | 1 | Parity-checking enable control bit |
| evt_mask_i | input | 7 | Per-bit capture mask, 1 blocks capture |
| lb_wr_en_i | input | 1 | Local-bus write strobe |
| lb_clr_i | input | 7 | Local-bus write data for bits 6:0, 1 clears |
| lb_rd_data_o | output | 32 | Local-bus read data |
| cfg_rd_data_o | output | 32 | Configuration-side read data |
| main_clr_en_i | input | 1 | Main-copy clear strobe |
| main_clr_i | input | 6 | Main-copy clear bits in status-bit order |
| main_stat_o | output | 16 | Main status copy view |
| irq_o | output | 1 | Level interrupt to the local processor |

## Verification
The bench builds the block with its default parameters: a 32-bit word, seven implemented bits and a two-bit power-state field. With those values every old/new power-state pair can be enumerated directly, all seven mask bits can be exercised, and every main-copy position can be toggled. Random mixes of strobes, masks and both clear paths then explore the cases where the two copies of a bit drift apart.

// File: rtl/brg_err_pkg.sv
package brg_err_pkg;
    localparam int DATA_W = 32;
    localparam int NEV    = 7;
    localparam int NMAIN  = 6;
    localparam int MAIN_W = 16;
    localparam int PS_W   = 2;

    localparam int B_MPE  = 0;
    localparam int B_STA  = 1;
    localparam int B_RTA  = 2;
    localparam int B_RMA  = 3;
    localparam int B_SERR = 4;
    localparam int B_DPE  = 5;
    localparam int B_PST  = 6;

    typedef enum logic [PS_W-1:0] {
        PS_D0 = 2'b00,
        PS_D1 = 2'b01,
        PS_D2 = 2'b10,
        PS_D3 = 2'b11
    } pstate_e;

    // Position in the main status word of the copy of status bit k (k = 0..5)
    function automatic int main_pos(input int k);
        return (k == 0) ? 8 : k + 10;
    endfunction
endpackage

// File: rtl/brg_err_evt_dec.sv
module brg_err_evt_dec
    import brg_err_pkg::*;
(
    input  logic            pwr_wr_i,
    input  logic [PS_W-1:0] pwr_old_i,
    input  logic [PS_W-1:0] pwr_new_i,
    input  logic            wdpe_tgt_i,
    input  logic            rdpe_mst_i,
    input  logic            adpe_i,
    input  logic            serr_i,
    input  logic            mabt_mst_i,
    input  logic            tabt_mst_i,
    input  logic            tabt_tgt_i,
    input  logic            perr_i,
    input  logic            perr_mst_i,
    input  logic            par_chk_en_i,
    output logic [NEV-1:0]  ev_o
);
    logic to_d0, to_d3;

    always_comb begin
        to_d0 = (pwr_old_i == PS_D3) && (pwr_new_i == PS_D0);
        to_d3 = (pwr_old_i == PS_D0) && (pwr_new_i == PS_D3);
        ev_o          = '0;
        ev_o[B_PST]   = pwr_wr_i && (to_d0 || to_d3);
        ev_o[B_DPE]   = wdpe_tgt_i || rdpe_mst_i || adpe_i;
        ev_o[B_SERR]  = serr_i;
        ev_o[B_RMA]   = mabt_mst_i;
        ev_o[B_RTA]   = tabt_mst_i;
        ev_o[B_STA]   = tabt_tgt_i;
        ev_o[B_MPE]   = perr_i && perr_mst_i && par_chk_en_i;
    end
endmodule

// File: rtl/brg_err_w1c_bank.sv
module brg_err_w1c_bank #(
    parameter int W = 7
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] set_i,
    input  logic         clr_en_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] stat;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < W; b++) begin
            if (set_i[b])
                st_d.stat[b] = 1'b1;
            else if (clr_en_i && clr_i[b])
                st_d.stat[b] = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign q_o = st_q.stat;
endmodule

// File: rtl/brg_err_irq_stat.sv
module brg_err_irq_stat
    import brg_err_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pwr_wr_i,
    input  logic [PS_W-1:0]   pwr_old_i,
    input  logic [PS_W-1:0]   pwr_new_i,
    input  logic              wdpe_tgt_i,
    input  logic              rdpe_mst_i,
    input  logic              adpe_i,
    input  logic              serr_i,
    input  logic              mabt_mst_i,
    input  logic              tabt_mst_i,
    input  logic              tabt_tgt_i,
    input  logic              perr_i,
    input  logic              perr_mst_i,
    input  logic              par_chk_en_i,
    input  logic [NEV-1:0]    evt_mask_i,
    input  logic              lb_wr_en_i,
    input  logic [NEV-1:0]    lb_clr_i,
    output logic [DATA_W-1:0] lb_rd_data_o,
    output logic [DATA_W-1:0] cfg_rd_data_o,
    input  logic              main_clr_en_i,
    input  logic [NMAIN-1:0]  main_clr_i,
    output logic [MAIN_W-1:0] main_stat_o,
    output logic              irq_o
);
    logic [NEV-1:0]   ev_raw;
    logic [NEV-1:0]   ev_loc;
    logic [NEV-1:0]   loc_q;
    logic [NMAIN-1:0] main_q;

    brg_err_evt_dec u_dec (
        .pwr_wr_i     (pwr_wr_i),
        .pwr_old_i    (pwr_old_i),
        .pwr_new_i    (pwr_new_i),
        .wdpe_tgt_i   (wdpe_tgt_i),
        .rdpe_mst_i   (rdpe_mst_i),
        .adpe_i       (adpe_i),
        .serr_i       (serr_i),
        .mabt_mst_i   (mabt_mst_i),
        .tabt_mst_i   (tabt_mst_i),
        .tabt_tgt_i   (tabt_tgt_i),
        .perr_i       (perr_i),
        .perr_mst_i   (perr_mst_i),
        .par_chk_en_i (par_chk_en_i),
        .ev_o         (ev_raw)
    );

    assign ev_loc = ev_raw & ~evt_mask_i;

    brg_err_w1c_bank #(.W(NEV)) u_loc (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (ev_loc),
        .clr_en_i (lb_wr_en_i),
        .clr_i    (lb_clr_i),
        .q_o      (loc_q)
    );

    brg_err_w1c_bank #(.W(NMAIN)) u_main (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (ev_raw[NMAIN-1:0]),
        .clr_en_i (main_clr_en_i),
        .clr_i    (main_clr_i),
        .q_o      (main_q)
    );

    always_comb begin
        main_stat_o = '0;
        for (int k = 0; k < NMAIN; k++)
            main_stat_o[main_pos(k)] = main_q[k];
    end

    assign lb_rd_data_o  = {{(DATA_W-NEV){1'b0}}, loc_q};
    assign cfg_rd_data_o = lb_rd_data_o;
    assign irq_o         = |loc_q;
endmodule

// File: rtl/brg_err_irq_stat_chk.sv
module brg_err_irq_stat_chk
    import brg_err_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              serr_i,
    input logic [NEV-1:0]    evt_mask_i,
    input logic              lb_wr_en_i,
    input logic [NEV-1:0]    lb_clr_i,
    input logic [DATA_W-1:0] lb_rd_data_o,
    input logic [DATA_W-1:0] cfg_rd_data_o,
    input logic              main_clr_en_i,
    input logic [MAIN_W-1:0] main_stat_o,
    input logic              irq_o
);
    assert_reserved_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lb_rd_data_o[DATA_W-1:NEV] == '0);

    assert_views_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_rd_data_o == lb_rd_data_o);

    assert_clear_works_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lb_wr_en_i && lb_clr_i[B_SERR] && !serr_i) |=> !lb_rd_data_o[B_SERR]);

    assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (serr_i && !evt_mask_i[B_SERR]) |=> lb_rd_data_o[B_SERR]);

    assert_main_copy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        serr_i |=> main_stat_o[14]);

    assert_mask_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (serr_i && evt_mask_i[B_SERR] && !(lb_wr_en_i && lb_clr_i[B_SERR]))
        |=> $stable(lb_rd_data_o[B_SERR]));

    assert_main_indep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!serr_i && !main_clr_en_i) |=> $stable(main_stat_o[14]));

    assert_irq_level_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == (lb_rd_data_o[NEV-1:0] != '0));
endmodule

bind brg_err_irq_stat brg_err_irq_stat_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .serr_i        (serr_i),
    .evt_mask_i    (evt_mask_i),
    .lb_wr_en_i    (lb_wr_en_i),
    .lb_clr_i      (lb_clr_i),
    .lb_rd_data_o  (lb_rd_data_o),
    .cfg_rd_data_o (cfg_rd_data_o),
    .main_clr_en_i (main_clr_en_i),
    .main_stat_o   (main_stat_o),
    .irq_o         (irq_o)
);

// File: tb/sim_brg_err_irq_stat.sv
module sim_brg_err_irq_stat;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_wr = 0, wdpe = 0, rdpe = 0, adpe = 0, serr = 0, mabt = 0, tabt_m = 0, tabt_t = 0;
    logic perr = 0, perr_m = 0, pce = 0, lb_we = 0, mc_en = 0;
    logic [1:0] p_old = 0, p_new = 0;
    logic [6:0] mask = 0, lb_clr = 0;
    logic [5:0] mc = 0;
    logic [31:0] lb_rd, cfg_rd;
    logic [15:0] mstat;
    logic irq;

    logic [6:0] e_loc;
    logic [5:0] e_main;
    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    brg_err_irq_stat u0 (
        .clk_i(clk), .rst_ni(rst_n), .pwr_wr_i(pwr_wr), .pwr_old_i(p_old), .pwr_new_i(p_new),
        .wdpe_tgt_i(wdpe), .rdpe_mst_i(rdpe), .adpe_i(adpe), .serr_i(serr), .mabt_mst_i(mabt),
        .tabt_mst_i(tabt_m), .tabt_tgt_i(tabt_t), .perr_i(perr), .perr_mst_i(perr_m),
        .par_chk_en_i(pce), .evt_mask_i(mask), .lb_wr_en_i(lb_we), .lb_clr_i(lb_clr),
        .lb_rd_data_o(lb_rd), .cfg_rd_data_o(cfg_rd), .main_clr_en_i(mc_en), .main_clr_i(mc),
        .main_stat_o(mstat), .irq_o(irq)
    );

    function automatic logic [6:0] ev_ref();
        logic [6:0] e;
        e[6] = pwr_wr && ((p_old == 2'b11 && p_new == 2'b00) || (p_old == 2'b00 && p_new == 2'b11));
        e[5] = wdpe | rdpe | adpe;
        e[4] = serr;
        e[3] = mabt;
        e[2] = tabt_m;
        e[1] = tabt_t;
        e[0] = perr & perr_m & pce;
        return e;
    endfunction

    function automatic logic [15:0] main_view(input logic [5:0] m);
        logic [15:0] v = '0;
        v[8] = m[0]; v[11] = m[1]; v[12] = m[2]; v[13] = m[3]; v[14] = m[4]; v[15] = m[5];
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        pwr_wr = 0; wdpe = 0; rdpe = 0; adpe = 0; serr = 0; mabt = 0; tabt_m = 0; tabt_t = 0;
        perr = 0; perr_m = 0; pce = 0; lb_we = 0; mc_en = 0; lb_clr = 0; mc = 0;
    endtask

    // Inputs already set after a negedge; advance one cycle, update model, compare.
    task automatic step(input string tag);
        logic [6:0] e = ev_ref();
        for (int b = 0; b < 7; b++) begin
            if (e[b] && !mask[b]) e_loc[b] = 1'b1;
            else if (lb_we && lb_clr[b]) e_loc[b] = 1'b0;
        end
        for (int k = 0; k < 6; k++) begin
            if (e[k]) e_main[k] = 1'b1;
            else if (mc_en && mc[k]) e_main[k] = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        chk({tag, " lb"}, lb_rd, {25'd0, e_loc});
        chk("R2 cfg view", cfg_rd, {25'd0, e_loc});
        chk("R5 main", {16'd0, mstat}, {16'd0, main_view(e_main)});
        chk("R11 irq", {31'd0, irq}, {31'd0, |e_loc});
    endtask

    task automatic clear_all();
        idle(); lb_we = 1; lb_clr = 7'h7f; mc_en = 1; mc = 6'h3f; mask = 0;
        step("R3 clear all");
        idle();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<200000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        e_loc = 0; e_main = 0;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 reset lb", lb_rd, 0);
        chk("R1 reset main", {16'd0, mstat}, 0);
        chk("R1 reset irq", {31'd0, irq}, 0);

        // R7 every power-state pair
        for (int o = 0; o < 4; o++) begin
            for (int n = 0; n < 4; n++) begin
                clear_all();
                pwr_wr = 1; p_old = 2'(o); p_new = 2'(n);
                step("R7 pwr pair");
                idle();
            end
        end
        // R7 no write strobe, no set
        clear_all(); p_old = 2'b11; p_new = 2'b00; step("R7 no strobe");

        // R10 each partial combination
        for (int c = 0; c < 8; c++) begin
            clear_all();
            perr = c[0]; perr_m = c[1]; pce = c[2];
            step("R10 mpe cond");
        end

        // R8 each parity source, with checking disabled
        clear_all(); wdpe = 1; step("R8 wdpe");
        clear_all(); rdpe = 1; step("R8 rdpe");
        clear_all(); adpe = 1; step("R8 adpe");

        // R9 mapping
        clear_all(); serr = 1; step("R9 serr");
        clear_all(); mabt = 1; step("R9 mabt");
        clear_all(); tabt_m = 1; step("R9 tabt mst");
        clear_all(); tabt_t = 1; step("R9 tabt tgt");

        // R4 set beats clear same cycle
        clear_all(); serr = 1; step("R4 preset");
        idle(); serr = 1; lb_we = 1; lb_clr = 7'h7f; step("R4 set wins");
        // R3 write zero leaves bit, write one clears it
        idle(); lb_we = 1; lb_clr = 7'h00; step("R3 zero keeps");
        idle(); lb_we = 1; lb_clr = 7'h10; step("R3 one clears");
        // R5 main copy still set after local clear
        chk("R5 main kept", {16'd0, mstat}, 32'h4000);

        // R6 mask blocks local only
        clear_all(); mask = 7'h7f; serr = 1; adpe = 1; pwr_wr = 1; p_old = 2'b00; p_new = 2'b11;
        step("R6 masked");
        mask = 0;

        // Random mix: R3 R4 R5 R6 R8 R9 R10 R11
        clear_all();
        for (int i = 0; i < 3000; i++) begin
            pwr_wr = ($urandom_range(0, 3) == 0); p_old = 2'($urandom); p_new = 2'($urandom);
            wdpe = ($urandom_range(0, 9) == 0); rdpe = ($urandom_range(0, 9) == 0);
            adpe = ($urandom_range(0, 9) == 0); serr = ($urandom_range(0, 5) == 0);
            mabt = ($urandom_range(0, 5) == 0); tabt_m = ($urandom_range(0, 5) == 0);
            tabt_t = ($urandom_range(0, 5) == 0);
            perr = $urandom_range(0, 1) == 1; perr_m = $urandom_range(0, 1) == 1;
            pce = $urandom_range(0, 1) == 1;
            mask = 7'($urandom);
            lb_we = ($urandom_range(0, 2) == 0); lb_clr = 7'($urandom);
            mc_en = ($urandom_range(0, 2) == 0); mc = 6'($urandom);
            step("R6 R9 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule